// File: doc/BRIEF.md
# Cache Selection Register with Access Trap

This block is a privileged system register that names one cache, by level and by kind (instruction, data or unified, or allocation-tag), so that a later cache-size query knows which description to return. The register holds five meaningful bits. Every other bit reads as zero and ignores writes.

System-register accesses arrive over a valid/ready request port. Each request carries a five-field instruction encoding, a read/write flag, write data, the current privilege level (0 to 3), and the hypervisor state and trap-control bits. The block checks the encoding. It then chooses one of four outcomes: the access is not for this register, the access completes, the access raises an undefined-instruction indication, or the access traps to privilege level 2 with a syndrome class. The outcome and any read data are returned one cycle after the request is accepted.

The parameter `MAX_LEVEL` sets how many cache levels exist. Selecting a level beyond that range reads back as zero. The parameter `TAG_EN` sets whether the allocation-tag cache selection exists.

Top module: `csel_reg`

## Requirements
- R1: Synchronous active-high reset clears `rsp_valid`, `rsp_undef`, `rsp_trap`, `rsp_class` and `rsp_rdata`, and clears the stored selection, so that the first permitted read returns zero.
- R2: `req_ready` is high whenever reset is low. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `rsp_valid` is high in exactly the cycle after an accepted request and low otherwise.
- R3: The request addresses this register only when op0=2'b11, op1=3'b010, crn=4'b0000, crm=4'b0000 and op2=3'b000. Any other encoding returns a response with no flags, zero data and class zero, and leaves the register unchanged.
- R4: A matching access at privilege level 0 returns `rsp_undef`=1 with zero data, and leaves the register unchanged.
- R5: A matching access at level 1 traps when `hyp_en`=1, `hyp_64`=1 and at least one of `tid2` or `tid4` is 1. A trapped access returns `rsp_trap`=1 with `rsp_class`=6'h18 and zero data, and leaves the register unchanged.
- R6: A matching access at level 1 that does not trap, or at level 2 or 3, completes. A read returns the register view. A write updates the register and returns zero data.
- R7: Bits 63 to 5 of read data are always zero, and writing them has no effect.
- R8: Bit 0 selects the cache kind: 0 means data or unified, 1 means instruction. Bits 3 to 1 hold the level minus one.
- R9: Bit 4 selects the allocation-tag cache. It is stored only when `TAG_EN`=1 and written bit 0 is 0. Otherwise it reads as 0.
- R10: When the stored level field (bits 3 to 1) is at least `MAX_LEVEL`, which includes the reserved value 3'b111, a read returns zero in bits 4 to 0.
- R11: `rsp_undef` and `rsp_trap` are never high together. `rsp_class` is zero in every response that is not a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_el | input | 2 | Current privilege level |
| req_wdata | input | DATA_W | Write data |
| hyp_en | input | 1 | Privilege level 2 is enabled |
| hyp_64 | input | 1 | Privilege level 2 runs in 64-bit state |
| tid2 | input | 1 | Trap control bit for ID-group accesses |
| tid4 | input | 1 | Trap control bit for cache-selection accesses |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Read data |
| rsp_undef | output | 1 | Undefined-instruction indication |
| rsp_trap | output | 1 | Trap to privilege level 2 |
| rsp_class | output | 6 | Syndrome exception class |

## Verification
The bench builds two instances that share all inputs. The first uses `MAX_LEVEL`=3 and `TAG_EN`=1, so three levels and the tag bit are live and levels 4 to 8 read back as zero. The second uses `MAX_LEVEL`=7 and `TAG_EN`=0, so all seven levels are valid, the tag bit is always dropped, and only the reserved value 3'b111 reads as zero. The bench sweeps all four privilege levels against all sixteen hypervisor and trap-bit combinations, writes all 32 values of the low five bits, and corrupts each encoding field in turn. After every denied access it reads the register back at level 3 to confirm that nothing changed.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_enc_t;

    localparam sysreg_enc_t CSEL_ENC = '{
        op0: 2'b11, op1: 3'b010, crn: 4'b0000, crm: 4'b0000, op2: 3'b000
    };

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_DO,
        ACT_UNDEF,
        ACT_TRAP
    } access_act_t;

    localparam logic [5:0] TRAP_CLASS_SYSREG = 6'h18;
    localparam int         FIELD_W           = 5;

    typedef struct packed {
        logic       tag;
        logic [2:0] level;
        logic       instr;
    } csel_fields_t;

    function automatic csel_fields_t pack_write(input logic [FIELD_W-1:0] raw,
                                                input logic tag_en);
        csel_fields_t f;
        f.instr = raw[0];
        f.level = raw[3:1];
        f.tag   = raw[4] & tag_en & ~raw[0];
        return f;
    endfunction

endpackage

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
(
    input  sysreg_enc_t enc,
    input  logic [1:0]  el,
    input  logic        hyp_en,
    input  logic        hyp_64,
    input  logic        tid2,
    input  logic        tid4,
    output access_act_t act
);

    logic trap_cond;
    assign trap_cond = hyp_en & hyp_64 & (tid2 | tid4);

    always_comb begin
        if (enc != CSEL_ENC) begin
            act = ACT_NONE;
        end else begin
            case (el)
                2'd0:    act = ACT_UNDEF;
                2'd1:    act = trap_cond ? ACT_TRAP : ACT_DO;
                default: act = ACT_DO;
            endcase
        end
    end

endmodule

// File: rtl/csel_store.sv
module csel_store
    import csel_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int MAX_LEVEL = 3,
    parameter bit TAG_EN    = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_raw,
    output logic [DATA_W-1:0]  rd_view
);

    localparam logic [3:0] LVL_LIMIT = 4'(MAX_LEVEL);
    localparam int         PAD_W     = DATA_W - FIELD_W;

    csel_fields_t cur;
    logic         lvl_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (wr_en) begin
            cur <= pack_write(wr_raw, TAG_EN);
        end
    end

    assign lvl_ok  = {1'b0, cur.level} < LVL_LIMIT;
    assign rd_view = lvl_ok ? {{PAD_W{1'b0}}, cur} : '0;

endmodule

// File: rtl/csel_reg.sv
module csel_reg
    import csel_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int MAX_LEVEL = 3,
    parameter bit TAG_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [1:0]        req_el,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hyp_en,
    input  logic              hyp_64,
    input  logic              tid2,
    input  logic              tid4,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic [5:0]        rsp_class
);

    sysreg_enc_t       enc;
    access_act_t       act;
    logic              accept;
    logic              wr_en;
    logic [DATA_W-1:0] view;
    logic              unused_wdata_hi;

    assign enc             = '{op0: req_op0, op1: req_op1, crn: req_crn,
                               crm: req_crm, op2: req_op2};
    assign req_ready       = ~rst;
    assign accept          = req_valid & req_ready;
    assign wr_en           = accept & req_write & (act == ACT_DO);
    assign unused_wdata_hi = ^req_wdata[DATA_W-1:FIELD_W];

    csel_decode u_decode (
        .enc    (enc),
        .el     (req_el),
        .hyp_en (hyp_en),
        .hyp_64 (hyp_64),
        .tid2   (tid2),
        .tid4   (tid4),
        .act    (act)
    );

    csel_store #(
        .DATA_W    (DATA_W),
        .MAX_LEVEL (MAX_LEVEL),
        .TAG_EN    (TAG_EN)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_raw  (req_wdata[FIELD_W-1:0]),
        .rd_view (view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_undef <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_class <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_undef <= accept && (act == ACT_UNDEF);
            rsp_trap  <= accept && (act == ACT_TRAP);
            rsp_class <= (accept && (act == ACT_TRAP)) ? TRAP_CLASS_SYSREG : 6'd0;
            rsp_rdata <= (accept && !req_write && (act == ACT_DO)) ? view : '0;
        end
    end

endmodule

// File: rtl/csel_reg_chk.sv
module csel_reg_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op0,
    input logic [2:0]        req_op1,
    input logic [3:0]        req_crn,
    input logic [3:0]        req_crm,
    input logic [2:0]        req_op2,
    input logic [1:0]        req_el,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_undef,
    input logic              rsp_trap,
    input logic [5:0]        rsp_class
);

    logic acc, hit;
    assign acc = req_valid && req_ready;
    assign hit = (req_op0 == 2'b11) && (req_op1 == 3'b010) && (req_crn == 4'd0)
              && (req_crm == 4'd0) && (req_op2 == 3'b000);

    AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);                                             // R2
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);                                           // R2
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc && !hit) |=> (!rsp_undef && !rsp_trap && rsp_rdata == '0)); // R3
    AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (acc && hit && req_el == 2'd0) |=> (rsp_undef && rsp_rdata == '0)); // R4
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_class == 6'h18 && rsp_rdata == '0));          // R5
    AST_RES_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_rdata[DATA_W-1:5] == '0);                                   // R7
    AST_TAG_VS_INSTR: assert property (@(posedge clk) disable iff (rst)
        rsp_rdata[0] |-> !rsp_rdata[4]);                                // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_undef && rsp_trap));                                      // R11
    AST_CLASS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rsp_trap |-> (rsp_class == 6'd0));                             // R11

endmodule

bind csel_reg csel_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_csel_reg.sv
module test_csel_reg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b010;
    logic [3:0]  req_crn = 4'd0;
    logic [3:0]  req_crm = 4'd0;
    logic [2:0]  req_op2 = 3'd0;
    logic [1:0]  req_el = 2'd3;
    logic [63:0] req_wdata = '0;
    logic        hyp_en = 1'b0, hyp_64 = 1'b0, tid2 = 1'b0, tid4 = 1'b0;

    logic        a_ready, a_valid, a_undef, a_trap;
    logic [63:0] a_rdata;
    logic [5:0]  a_class;
    logic        b_ready, b_valid, b_undef, b_trap;
    logic [63:0] b_rdata;
    logic [5:0]  b_class;

    int checks = 0;
    int fails  = 0;
    logic [4:0] model_a = '0;
    logic [4:0] model_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_reg #(.DATA_W(64), .MAX_LEVEL(3), .TAG_EN(1'b1)) i_csel_reg (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(a_ready),
        .req_write(req_write), .req_op0(req_op0), .req_op1(req_op1),
        .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .req_el(req_el), .req_wdata(req_wdata), .hyp_en(hyp_en),
        .hyp_64(hyp_64), .tid2(tid2), .tid4(tid4), .rsp_valid(a_valid),
        .rsp_rdata(a_rdata), .rsp_undef(a_undef), .rsp_trap(a_trap),
        .rsp_class(a_class));

    csel_reg #(.DATA_W(64), .MAX_LEVEL(7), .TAG_EN(1'b0)) i_csel_reg_notag (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(b_ready),
        .req_write(req_write), .req_op0(req_op0), .req_op1(req_op1),
        .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .req_el(req_el), .req_wdata(req_wdata), .hyp_en(hyp_en),
        .hyp_64(hyp_64), .tid2(tid2), .tid4(tid4), .rsp_valid(b_valid),
        .rsp_rdata(b_rdata), .rsp_undef(b_undef), .rsp_trap(b_trap),
        .rsp_class(b_class));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] stored(input logic [4:0] w, input logic tag_en);
        return {w[4] & tag_en & ~w[0], w[3:0]};
    endfunction

    function automatic logic [63:0] view(input logic [4:0] s, input int maxl);
        return (int'(s[3:1]) >= maxl) ? 64'd0 : {59'd0, s};
    endfunction

    // Drive one request. The caller is at a falling edge; outputs are sampled at the next one.
    task automatic issue();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_ctx(input logic [1:0] el, input logic [3:0] h);
        req_el = el;
        {hyp_en, hyp_64, tid2, tid4} = h;
    endtask

    task automatic readback(input string tag);
        set_ctx(2'd3, 4'd0);
        req_write = 1'b0;
        issue();
        chk({tag, " A"}, a_rdata, view(model_a, 3));
        chk({tag, " B"}, b_rdata, view(model_b, 7));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {63'd0, a_valid | b_valid}, 64'd0);
        chk("R1 rdata in reset", a_rdata | b_rdata, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 ready", {62'd0, a_ready, b_ready}, 64'd3);
        readback("R1 first read");
        chk("R2 response valid", {62'd0, a_valid, b_valid}, 64'd3);
        @(negedge clk);
        chk("R2 no response when idle", {62'd0, a_valid, b_valid}, 64'd0);

        // Privilege-level and trap-bit sweep: R4 R5 R6 R11
        for (int e = 0; e < 4; e++) begin
            for (int h = 0; h < 16; h++) begin
                logic [3:0] hb;
                logic       undef, trap, eff;
                logic [4:0] pat;
                hb    = 4'(h);
                undef = (e == 0);
                trap  = (e == 1) && hb[3] && hb[2] && (hb[1] || hb[0]);
                eff   = !undef && !trap;
                pat   = 5'(h * 3 + e * 7 + 1);
                set_ctx(2'(e), hb);
                req_write = 1'b1;
                req_wdata = {32'hDEAD_BEEF, 27'h5A5A5A5, pat};
                issue();
                chk("R4 undef flag", {62'd0, a_undef, b_undef}, undef ? 64'd3 : 64'd0);
                chk("R5 trap flag", {62'd0, a_trap, b_trap}, trap ? 64'd3 : 64'd0);
                chk("R11 class", {52'd0, a_class, b_class},
                    trap ? {52'd0, 6'h18, 6'h18} : 64'd0);
                chk("R6 write returns zero data", a_rdata | b_rdata, 64'd0);
                if (eff) begin
                    model_a = stored(pat, 1'b1);
                    model_b = stored(pat, 1'b0);
                end
                req_write = 1'b0;
                issue();
                chk("R6 read in context A", a_rdata, eff ? view(model_a, 3) : 64'd0);
                chk("R6 read in context B", b_rdata, eff ? view(model_b, 7) : 64'd0);
                readback("R4 R5 state kept");
            end
        end

        // Field sweep over all low-bit values: R7 R8 R9 R10
        for (int v = 0; v < 32; v++) begin
            set_ctx(2'd2, 4'd0);
            req_write = 1'b1;
            req_wdata = {59'h7FF_FFFF_FFFF_FFFF, 5'(v)};
            issue();
            model_a = stored(5'(v), 1'b1);
            model_b = stored(5'(v), 1'b0);
            readback("R7 R8 R9 R10 field view");
        end

        // Encoding mismatch on each field: R3
        set_ctx(2'd3, 4'd0);
        req_write = 1'b1;
        req_wdata = 64'd2;
        issue();
        model_a = 5'd2;
        model_b = 5'd2;
        for (int f = 0; f < 5; f++) begin
            set_ctx(2'd3, 4'd0);
            req_write = 1'b1;
            req_wdata = 64'd5;
            case (f)
                0: req_op0 = 2'b10;
                1: req_op1 = 3'b000;
                2: req_crn = 4'd1;
                3: req_crm = 4'd1;
                default: req_op2 = 3'd1;
            endcase
            issue();
            chk("R3 miss flags", {58'd0, a_undef, a_trap, b_undef, b_trap, 2'b00}, 64'd0);
            chk("R3 miss data and class", a_rdata | b_rdata | {52'd0, a_class, b_class}, 64'd0);
            req_op0 = 2'b11; req_op1 = 3'b010; req_crn = 4'd0; req_crm = 4'd0; req_op2 = 3'd0;
            readback("R3 miss leaves register");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule